// File: doc/BRIEF.md
# Watchdog Timeout Controller with Interrupt or Reset Action

This block counts ticks from a slow free-running oscillator and raises an action when software fails to kick it in time. One 8-bit control/status register sets the behaviour. It holds an interrupt enable, a reset enable, a 4-bit period select and a change-enable bit that guards the settings. The timeout flag sits in the same register. A timeout can raise an interrupt request, a one-cycle system reset request, or an interrupt first and then a reset if the interrupt is left unserviced.

The reset enable can always be raised. Lowering it or changing the period select takes two writes. The first write opens a short window, and the change is accepted only if the second write lands inside that window. The interrupt enable is not protected.

The timeout flag clears in two ways: when the vector logic acknowledges the interrupt, or when software writes a one to it. The interrupt request leaves the block only when the processor's global interrupt enable is also set.

Top module: `watchdog_ctrl`

## Requirements
- R1: After reset the register reads 0x00. The register layout is:
  - bit 7: timeout flag
  - bit 6: interrupt enable
  - bit 5: period select bit 3
  - bit 4: change-window open
  - bit 3: reset enable
  - bits 2..0: period select bits 2..0
- R2: With period select n, the timer reaches timeout after 2^(BASE_LOG+n) cycles in which `osc_tick` is high. Cycles with `osc_tick` low do not count. Codes above 9 time out like code 9, and the raw code still reads back.
- R3: With the interrupt enable and the reset enable both 0, the counter is held at zero and no flag or reset request is produced.
- R4: With the reset enable 1 and the interrupt enable 0, a timeout drives `wdt_rst` high for exactly one cycle, in the cycle after the counting edge.
- R5: With the interrupt enable 1 and the reset enable 0, a timeout sets the flag and never drives `wdt_rst`.
- R6: `wdt_irq` is high exactly when the flag, the interrupt enable and `gie` are all 1.
- R7: The flag is cleared by `irq_ack`, or by a register write with bit 7 = 1. A write with bit 7 = 0 leaves it unchanged.
- R8: Lowering the reset enable, or changing the period select, is accepted only from a write made 1 to WIN_CYCLES (default 4) cycles after a write with bit 4 = 1 and bit 3 = 1. At any other time:
  - the period select keeps its value;
  - the reset enable can only be raised;
  - the interrupt enable is always written.
- R9: The change-window bit (bit 4) reads 1 for WIN_CYCLES cycles after the opening write and then reads 0 without any further write.
- R10: With both enables 1, a timeout while the flag is clear sets the flag without a reset request. A timeout while the flag is still set drives `wdt_rst` for one cycle.
- R11: A `kick` pulse restarts the timeout period from zero. Kicks spaced closer than the period prevent every timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| kick | input | 1 | Restart the timeout period |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| gie | input | 1 | Global interrupt enable from the processor |
| irq_ack | input | 1 | Vector entry acknowledge, clears the flag |
| wdt_irq | output | 1 | Timeout interrupt request |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches the following on every cycle:
- the reset request lasts a single cycle and is never driven in interrupt-only or disabled mode;
- the acknowledge clears the flag;
- the period select and the reset enable do not move while the window is closed;
- the window count stays within its bound;
- the first timeout in combined mode only sets the flag.

Only the directed scenarios show the exact period for each select code, including the clamp above code 9. They also show the effect of gaps in the tick stream, the edges of the four-cycle window on both sides, the decay of the change-window bit, and the escalation to reset on a second timeout in combined mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register bit positions decoded by software
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int PS3_BIT  = 5;
    localparam int CE_BIT   = 4;
    localparam int RE_BIT   = 3;

    // Action selected by {interrupt enable, reset enable}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RST  = 2'b01,
        MODE_IRQ  = 2'b10,
        MODE_BOTH = 2'b11
    } wdt_mode_e;

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int BASE_LOG = 11,
    parameter int NUM_SEL  = 10,
    localparam int CW      = BASE_LOG + NUM_SEL - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       kick,
    input  logic [3:0] ps,
    output logic       timeout
);

    localparam logic [3:0] SEL_MAX = 4'(NUM_SEL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t    q, d;
    logic [3:0] sel;
    logic [CW-1:0] limit;
    logic       hit;

    always_comb begin
        sel     = (ps > SEL_MAX) ? SEL_MAX : ps;
        limit   = {CW{1'b1}} >> (SEL_MAX - sel);
        hit     = (q.cnt >= limit);
        timeout = run && !kick && tick && hit;
        d       = q;
        if (!run || kick) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = hit ? '0 : q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
    import wdt_pkg::*;
#(
    parameter int WIN_CYCLES = 4,
    localparam int WW        = $clog2(WIN_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic          ie,
    output logic          re,
    output logic [3:0]    ps,
    output logic [WW-1:0] win
);

    typedef struct packed {
        logic          ie;
        logic          re;
        logic [3:0]    ps;
        logic [WW-1:0] win;
    } csr_st_t;

    csr_st_t q, d;
    logic    win_open;

    always_comb begin
        win_open = (q.win != '0);
        d        = q;
        if (win_open) begin
            d.win = q.win - WW'(1);
        end
        if (we) begin
            d.ie = wdata[IE_BIT];
            if (win_open) begin
                d.re = wdata[RE_BIT];
                d.ps = {wdata[PS3_BIT], wdata[2:0]};
            end else if (wdata[RE_BIT]) begin
                d.re = 1'b1;
            end
            if (wdata[CE_BIT] && wdata[RE_BIT]) begin
                d.win = WW'(WIN_CYCLES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ie  = q.ie;
    assign re  = q.re;
    assign ps  = q.ps;
    assign win = q.win;

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic ie,
    input  logic re,
    input  logic gie,
    input  logic irq_ack,
    input  logic sw_clear,
    output logic flag,
    output logic irq,
    output logic rst_req
);

    typedef struct packed {
        logic flag;
        logic rst;
    } act_st_t;

    act_st_t   q, d;
    wdt_mode_e mode;

    always_comb begin
        mode  = wdt_mode_e'({ie, re});
        d     = q;
        d.rst = 1'b0;
        if (irq_ack || sw_clear) begin
            d.flag = 1'b0;
        end
        if (timeout) begin
            unique case (mode)
                MODE_IRQ:  d.flag = 1'b1;
                MODE_RST:  d.rst  = 1'b1;
                MODE_BOTH: begin
                    if (q.flag) begin
                        d.rst = 1'b1;
                    end else begin
                        d.flag = 1'b1;
                    end
                end
                default:   d.rst  = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flag    = q.flag;
    assign irq     = q.flag && ie && gie;
    assign rst_req = q.rst;

endmodule

// File: rtl/watchdog_ctrl.sv
module watchdog_ctrl
    import wdt_pkg::*;
#(
    parameter int BASE_LOG   = 11,
    parameter int NUM_SEL    = 10,
    parameter int WIN_CYCLES = 4,
    localparam int WW        = $clog2(WIN_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       kick,
    input  logic       csr_we,
    input  logic [7:0] csr_wdata,
    output logic [7:0] csr_rdata,
    input  logic       gie,
    input  logic       irq_ack,
    output logic       wdt_irq,
    output logic       wdt_rst
);

    logic          csr_ie;
    logic          csr_re;
    logic [3:0]    csr_ps;
    logic [WW-1:0] csr_win;
    logic          timeout;
    logic          flag;
    logic          sw_clear;

    assign sw_clear = csr_we && csr_wdata[FLAG_BIT];

    wdt_csr #(
        .WIN_CYCLES (WIN_CYCLES)
    ) i_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (csr_we),
        .wdata (csr_wdata),
        .ie    (csr_ie),
        .re    (csr_re),
        .ps    (csr_ps),
        .win   (csr_win)
    );

    wdt_tick_counter #(
        .BASE_LOG (BASE_LOG),
        .NUM_SEL  (NUM_SEL)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (csr_ie || csr_re),
        .tick    (osc_tick),
        .kick    (kick),
        .ps      (csr_ps),
        .timeout (timeout)
    );

    wdt_action i_action (
        .clk      (clk),
        .rst_n    (rst_n),
        .timeout  (timeout),
        .ie       (csr_ie),
        .re       (csr_re),
        .gie      (gie),
        .irq_ack  (irq_ack),
        .sw_clear (sw_clear),
        .flag     (flag),
        .irq      (wdt_irq),
        .rst_req  (wdt_rst)
    );

    always_comb begin
        csr_rdata           = '0;
        csr_rdata[FLAG_BIT] = flag;
        csr_rdata[IE_BIT]   = csr_ie;
        csr_rdata[PS3_BIT]  = csr_ps[3];
        csr_rdata[CE_BIT]   = (csr_win != '0);
        csr_rdata[RE_BIT]   = csr_re;
        csr_rdata[2:0]      = csr_ps[2:0];
    end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int WIN_CYCLES = 4,
    localparam int WW        = $clog2(WIN_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gie,
    input logic          irq_ack,
    input logic          timeout,
    input logic          flag,
    input logic          irq,
    input logic          rst_pulse,
    input logic          ie,
    input logic          re,
    input logic [3:0]    ps,
    input logic [WW-1:0] win
);

    // R4
    rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R3
    off_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !re) |=> !rst_pulse);

    // R3
    off_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !re && !flag) |=> !flag);

    // R5
    irq_mode_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && !re) |=> !rst_pulse);

    // R6
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && ie));

    // R7
    ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !timeout) |=> !flag);

    // R8
    ps_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win == '0) |=> $stable(ps));

    // R8
    re_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win == '0 && re) |=> re);

    // R9
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win <= WW'(WIN_CYCLES));

    // R10
    both_first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && re && !flag && timeout) |=> (flag && !rst_pulse));

endmodule

bind watchdog_ctrl wdt_checker #(
    .WIN_CYCLES (WIN_CYCLES)
) i_wdt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie),
    .irq_ack   (irq_ack),
    .timeout   (timeout),
    .flag      (flag),
    .irq       (wdt_irq),
    .rst_pulse (wdt_rst),
    .ie        (csr_ie),
    .re        (csr_re),
    .ps        (csr_ps),
    .win       (csr_win)
);

// File: tb/test_watchdog_ctrl.sv
module test_watchdog_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_LOG   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       kick = 1'b0;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       wdt_irq;
    logic       wdt_rst;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    watchdog_ctrl #(
        .BASE_LOG (BASE_LOG)
    ) i_watchdog_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .kick      (kick),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .gie       (gie),
        .irq_ack   (irq_ack),
        .wdt_irq   (wdt_irq),
        .wdt_rst   (wdt_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic do_reset();
        rst_n = 1'b0; csr_we = 1'b0; kick = 1'b0; irq_ack = 1'b0;
        gie = 1'b0; osc_tick = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] v);
        csr_we = 1'b1; csr_wdata = v;
        @(posedge clk);
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        kick = 1'b0;
    endtask

    // Counts edges until the reset request (want_rst) or the flag appears
    task automatic measure(input bit want_rst, output int n, output bit saw_rst);
        n = -1;
        saw_rst = 1'b0;
        for (int i = 1; i <= 20000; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (wdt_rst) saw_rst = 1'b1;
            if (want_rst ? wdt_rst : csr_rdata[7]) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 reset rdata", csr_rdata, 8'h00);
        chk("R1 reset irq", wdt_irq, 0);
        chk("R1 reset rst", wdt_rst, 0);
    endtask

    task automatic t_layout();
        do_reset();
        wr(8'h18);
        chk("R1 open write readback", csr_rdata, 8'h18);
        wr(8'h6D);
        chk("R1 layout readback", csr_rdata, 8'h7D);
    endtask

    task automatic t_window();
        do_reset();
        wr(8'h18);
        chk("R9 ce after open", csr_rdata[4], 1);
        idle(3);
        chk("R9 ce last window cycle", csr_rdata[4], 1);
        idle(1);
        chk("R9 ce decayed", csr_rdata[4], 0);
        do_reset();
        wr(8'h18);
        idle(3);
        wr(8'h0A);
        chk("R8 write in 4th cycle accepted", csr_rdata, 8'h0A);
        wr(8'h18);
        idle(4);
        wr(8'h0B);
        chk("R8 write in 5th cycle ignored", csr_rdata, 8'h0A);
        wr(8'h00);
        chk("R8 re lowering without window ignored", csr_rdata, 8'h0A);
        wr(8'h4A);
        chk("R8 ie written freely", csr_rdata, 8'h4A);
    endtask

    task automatic t_reset_mode();
        int n;
        bit s;
        do_reset();
        wr(8'h18);
        wr(8'h08);
        do_kick();
        measure(1'b1, n, s);
        chk("R2 period code 0", n, 8);
        chk("R5 no flag in reset mode", csr_rdata[7], 0);
        idle(1);
        chk("R4 reset pulse one cycle", wdt_rst, 0);
        wr(8'h18);
        wr(8'h0A);
        do_kick();
        measure(1'b1, n, s);
        chk("R2 period code 2", n, 32);
        wr(8'h18);
        wr(8'h2C);
        chk("R2 code 12 reads back", csr_rdata, 8'h3C);
        do_kick();
        measure(1'b1, n, s);
        chk("R2 code 12 clamps to 9", n, 4096);
    endtask

    task automatic t_kick_and_tick();
        int n;
        bit s;
        bit seen;
        do_reset();
        wr(8'h18);
        wr(8'h08);
        do_kick();
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (wdt_rst) seen = 1'b1;
            end
            do_kick();
            if (wdt_rst) seen = 1'b1;
        end
        chk("R11 frequent kicks prevent reset", seen, 0);
        measure(1'b1, n, s);
        chk("R11 period restarts at kick", n, 8);
        osc_tick = 1'b0;
        do_kick();
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wdt_rst) seen = 1'b1;
        end
        chk("R2 no count without tick", seen, 0);
        osc_tick = 1'b1;
        measure(1'b1, n, s);
        chk("R2 only tick cycles count", n, 8);
    endtask

    task automatic t_irq_mode();
        int n;
        bit s;
        do_reset();
        wr(8'h58);
        wr(8'h41);
        chk("R8 re lowered inside window", csr_rdata, 8'h51);
        do_kick();
        measure(1'b0, n, s);
        chk("R2 irq period code 1", n, 16);
        chk("R5 no reset in irq mode", s, 0);
        chk("R6 irq low without gie", wdt_irq, 0);
        gie = 1'b1;
        #1;
        chk("R6 irq with gie", wdt_irq, 1);
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 ack clears flag", csr_rdata[7], 0);
        chk("R7 irq drops after ack", wdt_irq, 0);
        do_kick();
        measure(1'b0, n, s);
        chk("R5 flag sets again", n, 16);
        wr(8'h41);
        chk("R7 write zero keeps flag", csr_rdata[7], 1);
        wr(8'h01);
        chk("R6 irq masked by ie", wdt_irq, 0);
        chk("R6 flag kept while masked", csr_rdata[7], 1);
        wr(8'hC1);
        chk("R7 write one clears flag", csr_rdata[7], 0);
    endtask

    task automatic t_both_mode();
        int n;
        bit s;
        do_reset();
        gie = 1'b1;
        wr(8'h58);
        wr(8'h48);
        do_kick();
        measure(1'b0, n, s);
        chk("R10 first timeout sets flag", n, 8);
        chk("R10 no reset on first timeout", s, 0);
        chk("R6 irq in combined mode", wdt_irq, 1);
        measure(1'b1, n, s);
        chk("R10 second timeout resets", n, 8);
    endtask

    task automatic t_disabled();
        bit seen;
        do_reset();
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wdt_rst || csr_rdata[7]) seen = 1'b1;
        end
        chk("R3 idle after reset", seen, 0);
        wr(8'h18);
        wr(8'h00);
        chk("R3 both enables cleared", csr_rdata, 8'h10);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wdt_rst || csr_rdata[7]) seen = 1'b1;
        end
        chk("R3 stopped after disable", seen, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_layout();
        t_window();
        t_reset_mode();
        t_kick_and_tick();
        t_irq_mode();
        t_both_mode();
        t_disabled();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule